// File: doc/BRIEF.md
# Receive-Side Xon/Xoff Flow Filter

This block sits between a UART receiver and its receive FIFO. It looks at every received character and compares it with four programmed codes: two resume codes and two pause codes. A character, or a two-character sequence, that matches a pause code raises a halt request for the local transmitter. A matching resume code or sequence clears the request. Matched codes are consumed and are not written to the FIFO. Every other character is forwarded to the FIFO unchanged.

A mode input selects single-code or two-code matching. A second mode lets any received character end a pause. The halt output to the transmitter only rises at a character boundary that the transmitter reports, so a character already being sent is never cut short. Each recognised pause event raises a one-cycle interrupt pulse.

Receive strobes are expected at least three clock cycles apart. In practice a serial character takes far longer than that. The spacing leaves room for the two back-to-back FIFO writes that a cancelled sequence produces.

Top module: `xfc_rx_flow`

## Requirements
- R1: While `rst_ni` is low, `tx_halt_o`, `fifo_wr_o` and `xoff_irq_o` are low and no partial sequence is held.
- R2: With `fc_en_i` low, every strobed character appears on `fifo_wr_o`/`fifo_data_o` one cycle after its strobe, unchanged. No interrupt is raised and `tx_halt_o` stays low.
- R3: In single mode (`dbl_mode_i`=0), a character equal to `xoff1_i` sets the halt request and one equal to `xon1_i` clears it. Neither is written to the FIFO. Any other character is written one cycle after its strobe.
- R4: In double mode (`dbl_mode_i`=1), the halt request is set only by `xoff1_i` immediately followed by `xoff2_i`, and cleared only by `xon1_i` immediately followed by `xon2_i`. Both characters of a matched pair are consumed.
- R5: In double mode, if a first code is followed by a character that is not its partner, the held first character is written one cycle after the second strobe. The second character is written in the following cycle.
- R6: `xoff_irq_o` pulses high for exactly one cycle, one cycle after the strobe that completes a pause code or pause sequence.
- R7: With `xon_any_i` high, the halt request set and no partial sequence held, any received character clears the request. That character is written to the FIFO unless it equals `xon1_i`.
- R8: In double mode with `xon_any_i` high while halted, `xon1_i` is consumed as the resuming character. An `xon2_i` that follows it is written to the FIFO as ordinary data.
- R9: `tx_halt_o` rises only on a clock edge where `tx_boundary_i` is high and the halt request is set. It falls on the same edge that clears the request.
- R10: Driving `fc_en_i` low drops `tx_halt_o` one cycle later and discards any held first character. After re-enabling, a lone second code is treated as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fc_en_i | input | 1 | Software flow control enable |
| dbl_mode_i | input | 1 | 0: single-code match, 1: two-code sequence match |
| xon_any_i | input | 1 | Any received character ends a pause |
| xon1_i | input | W | First resume code |
| xon2_i | input | W | Second resume code |
| xoff1_i | input | W | First pause code |
| xoff2_i | input | W | Second pause code |
| rx_valid_i | input | 1 | One-cycle strobe for a received character |
| rx_data_i | input | W | Received character |
| tx_boundary_i | input | 1 | Transmitter is between characters |
| tx_halt_o | output | 1 | Hold the transmitter before its next character |
| fifo_wr_o | output | 1 | Write strobe to the receive FIFO |
| fifo_data_o | output | W | Character to the receive FIFO |
| xoff_irq_o | output | 1 | One-cycle pause-received event |

## Verification
FIFO writes and the interrupt are due in the cycle after the receive strobe. The second write of a cancelled pair is due one cycle after that. `tx_halt_o` changes on the same edge as the halt request, but a rise also needs the boundary input high on that edge.

The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares the outputs on the next falling edge, so every check lands exactly in the cycle its result is due. Directed checks sample at those same falling edges: right after the strobe for the first result, and one edge later for a flushed second character.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int unsigned N_CODES = 4;
  // code slot order inside the packed code vector
  localparam int unsigned C_ON1  = 0;
  localparam int unsigned C_ON2  = 1;
  localparam int unsigned C_OFF1 = 2;
  localparam int unsigned C_OFF2 = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ON1  = 2'd1,
    SEQ_OFF1 = 2'd2
  } seq_e;
endpackage

// File: rtl/xfc_code_match.sv
module xfc_code_match
  import xfc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]              data_i,
  input  logic [N_CODES-1:0][W-1:0] codes_i,
  output logic [N_CODES-1:0]        hit_o
);
  for (genvar g = 0; g < N_CODES; g++) begin : g_cmp
    assign hit_o[g] = (data_i == codes_i[g]);
  end
endmodule

// File: rtl/xfc_seq.sv
module xfc_seq
  import xfc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fc_en_i,
  input  logic               dbl_mode_i,
  input  logic               xon_any_i,
  input  logic               rx_valid_i,
  input  logic [W-1:0]       rx_data_i,
  input  logic [N_CODES-1:0] hit_i,
  output logic               halt_nxt_o,
  output logic               wr_o,
  output logic [W-1:0]       data_o,
  output logic               irq_o
);
  seq_e         seq_q, seq_d;
  logic [W-1:0] held_q, held_d;
  logic         halt_q, halt_d;
  logic         pend_vld_q, pend_vld_d;
  logic [W-1:0] pend_q, pend_d;
  logic         wr_d, irq_d;
  logic [W-1:0] data_d;

  always_comb begin
    seq_d      = seq_q;
    held_d     = held_q;
    halt_d     = halt_q;
    pend_vld_d = 1'b0;
    pend_d     = pend_q;
    wr_d       = pend_vld_q;   // second half of a cancelled pair
    data_d     = pend_q;
    irq_d      = 1'b0;
    if (!fc_en_i) begin
      seq_d  = SEQ_IDLE;
      halt_d = 1'b0;
      if (rx_valid_i) begin
        wr_d   = 1'b1;
        data_d = rx_data_i;
      end
    end else if (rx_valid_i) begin
      if (xon_any_i && halt_q && seq_q == SEQ_IDLE) begin
        halt_d = 1'b0;
        if (!hit_i[C_ON1]) begin
          wr_d   = 1'b1;
          data_d = rx_data_i;
        end
      end else if (!dbl_mode_i) begin
        seq_d = SEQ_IDLE;
        if (hit_i[C_OFF1]) begin
          halt_d = 1'b1;
          irq_d  = 1'b1;
        end else if (hit_i[C_ON1]) begin
          halt_d = 1'b0;
        end else begin
          wr_d   = 1'b1;
          data_d = rx_data_i;
        end
      end else begin
        unique case (seq_q)
          SEQ_IDLE: begin
            held_d = rx_data_i;
            if (hit_i[C_OFF1])     seq_d = SEQ_OFF1;
            else if (hit_i[C_ON1]) seq_d = SEQ_ON1;
            else begin
              wr_d   = 1'b1;
              data_d = rx_data_i;
            end
          end
          SEQ_OFF1, SEQ_ON1: begin
            seq_d = SEQ_IDLE;
            if (seq_q == SEQ_OFF1 && hit_i[C_OFF2]) begin
              halt_d = 1'b1;
              irq_d  = 1'b1;
            end else if (seq_q == SEQ_ON1 && hit_i[C_ON2]) begin
              halt_d = 1'b0;
            end else begin
              wr_d       = 1'b1;
              data_d     = held_q;
              pend_vld_d = 1'b1;
              pend_d     = rx_data_i;
            end
          end
          default: seq_d = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q      <= SEQ_IDLE;
      held_q     <= '0;
      halt_q     <= 1'b0;
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
      wr_o       <= 1'b0;
      data_o     <= '0;
      irq_o      <= 1'b0;
    end else begin
      seq_q      <= seq_d;
      held_q     <= held_d;
      halt_q     <= halt_d;
      pend_vld_q <= pend_vld_d;
      pend_q     <= pend_d;
      wr_o       <= wr_d;
      data_o     <= data_d;
      irq_o      <= irq_d;
    end
  end

  assign halt_nxt_o = halt_d;
endmodule

// File: rtl/xfc_tx_gate.sv
module xfc_tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_nxt_i,
  input  logic tx_boundary_i,
  output logic tx_halt_o
);
  // rise only between characters, fall at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_halt_o <= 1'b0;
    else         tx_halt_o <= halt_nxt_i & (tx_halt_o | tx_boundary_i);
  end
endmodule

// File: rtl/xfc_rx_flow.sv
module xfc_rx_flow
  import xfc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fc_en_i,
  input  logic         dbl_mode_i,
  input  logic         xon_any_i,
  input  logic [W-1:0] xon1_i,
  input  logic [W-1:0] xon2_i,
  input  logic [W-1:0] xoff1_i,
  input  logic [W-1:0] xoff2_i,
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_data_i,
  input  logic         tx_boundary_i,
  output logic         tx_halt_o,
  output logic         fifo_wr_o,
  output logic [W-1:0] fifo_data_o,
  output logic         xoff_irq_o
);
  logic [N_CODES-1:0][W-1:0] codes;
  logic [N_CODES-1:0]        hit;
  logic                      halt_nxt;

  assign codes[C_ON1]  = xon1_i;
  assign codes[C_ON2]  = xon2_i;
  assign codes[C_OFF1] = xoff1_i;
  assign codes[C_OFF2] = xoff2_i;

  xfc_code_match #(.W(W)) u_match (
    .data_i (rx_data_i),
    .codes_i(codes),
    .hit_o  (hit)
  );

  xfc_seq #(.W(W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fc_en_i   (fc_en_i),
    .dbl_mode_i(dbl_mode_i),
    .xon_any_i (xon_any_i),
    .rx_valid_i(rx_valid_i),
    .rx_data_i (rx_data_i),
    .hit_i     (hit),
    .halt_nxt_o(halt_nxt),
    .wr_o      (fifo_wr_o),
    .data_o    (fifo_data_o),
    .irq_o     (xoff_irq_o)
  );

  xfc_tx_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_nxt_i   (halt_nxt),
    .tx_boundary_i(tx_boundary_i),
    .tx_halt_o    (tx_halt_o)
  );
endmodule

// File: rtl/xfc_rx_flow_chk.sv
module xfc_rx_flow_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         fc_en_i,
  input logic         dbl_mode_i,
  input logic [W-1:0] xoff1_i,
  input logic         rx_valid_i,
  input logic [W-1:0] rx_data_i,
  input logic         tx_boundary_i,
  input logic         tx_halt_o,
  input logic         fifo_wr_o,
  input logic [W-1:0] fifo_data_o,
  input logic         xoff_irq_o
);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!tx_halt_o && !fifo_wr_o && !xoff_irq_o);
    end
  end

  assert_passthru_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fc_en_i && rx_valid_i) |=> (fifo_wr_o && fifo_data_o == $past(rx_data_i)));

  assert_xoff_consumed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_en_i && !dbl_mode_i && rx_valid_i && rx_data_i == xoff1_i) |=> !fifo_wr_o);

  assert_irq_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xoff_irq_o |-> ($past(rx_valid_i) && $past(fc_en_i)));

  assert_irq_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xoff_irq_o |=> !xoff_irq_o);

  assert_halt_at_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_halt_o) |-> $past(tx_boundary_i));

  assert_disable_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fc_en_i |=> !tx_halt_o);
endmodule

bind xfc_rx_flow xfc_rx_flow_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fc_en_i      (fc_en_i),
  .dbl_mode_i   (dbl_mode_i),
  .xoff1_i      (xoff1_i),
  .rx_valid_i   (rx_valid_i),
  .rx_data_i    (rx_data_i),
  .tx_boundary_i(tx_boundary_i),
  .tx_halt_o    (tx_halt_o),
  .fifo_wr_o    (fifo_wr_o),
  .fifo_data_o  (fifo_data_o),
  .xoff_irq_o   (xoff_irq_o)
);

// File: tb/xfc_rx_flow_bench.sv
module xfc_rx_flow_bench;
  localparam int W = 8;
  localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h12, OFF1 = 8'h13, OFF2 = 8'h14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fc_en = 1'b0, dbl = 1'b0, any = 1'b0;
  logic rx_valid = 1'b0, bound = 1'b0;
  logic [W-1:0] rx_data = '0;
  logic tx_halt, fifo_wr, irq;
  logic [W-1:0] fifo_data;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xfc_rx_flow #(.W(W)) u_xfc_rx_flow (
    .clk_i(clk), .rst_ni(rst_n), .fc_en_i(fc_en), .dbl_mode_i(dbl),
    .xon_any_i(any), .xon1_i(ON1), .xon2_i(ON2), .xoff1_i(OFF1), .xoff2_i(OFF2),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .tx_boundary_i(bound),
    .tx_halt_o(tx_halt), .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data),
    .xoff_irq_o(irq)
  );

  // behavioural reference model
  int        part = 0;   // 0 none, 1 resume first seen, 2 pause first seen
  logic [7:0] held;
  bit        m_halt = 0;
  logic [7:0] q[$];
  bit        e_wr = 0, e_irq = 0, e_halt = 0;
  logic [7:0] e_data = 0;

  task automatic emit(input logic [7:0] c);
    if (!e_wr) begin e_wr = 1; e_data = c; end
    else q.push_back(c);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part = 0; m_halt = 0; q.delete(); e_wr = 0; e_irq = 0; e_halt = 0;
    end else begin
      e_wr = 0; e_irq = 0;
      if (q.size() > 0) begin e_wr = 1; e_data = q.pop_front(); end
      if (!fc_en) begin
        part = 0; m_halt = 0;
        if (rx_valid) emit(rx_data);
      end else if (rx_valid) begin
        if (any && m_halt && part == 0) begin
          m_halt = 0;
          if (rx_data != ON1) emit(rx_data);
        end else if (!dbl) begin
          part = 0;
          if (rx_data == OFF1) begin m_halt = 1; e_irq = 1; end
          else if (rx_data == ON1) m_halt = 0;
          else emit(rx_data);
        end else if (part == 0) begin
          held = rx_data;
          if (rx_data == OFF1) part = 2;
          else if (rx_data == ON1) part = 1;
          else emit(rx_data);
        end else begin
          if (part == 2 && rx_data == OFF2) begin m_halt = 1; e_irq = 1; end
          else if (part == 1 && rx_data == ON2) m_halt = 0;
          else begin emit(held); emit(rx_data); end
          part = 0;
        end
      end
      e_halt = m_halt && (e_halt || bound);
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 R3 fifo_wr per-cycle", fifo_wr, e_wr);
      if (e_wr) chk("R5 fifo_data per-cycle", fifo_data, e_data);
      chk("R6 xoff_irq per-cycle", irq, e_irq);
      chk("R9 tx_halt per-cycle", tx_halt, e_halt);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe one character; returns at the falling edge where its result is due
  task automatic send(input logic [7:0] c);
    @(negedge clk); rx_valid = 1; rx_data = c;
    @(negedge clk); rx_valid = 0;
  endtask

  initial begin
    #(20000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung exp=done");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 reset tx_halt", tx_halt, 0);
    chk("R1 reset fifo_wr", fifo_wr, 0);
    chk("R1 reset irq", irq, 0);
    rst_n = 1; idle(2);

    // R2: disabled, pause code passes through
    send(OFF1);
    chk("R2 wr", fifo_wr, 1); chk("R2 data", fifo_data, OFF1); chk("R2 irq", irq, 0);
    idle(2);

    // R3: single mode
    fc_en = 1; idle(1);
    send(8'h41); chk("R3 data wr", fifo_wr, 1); chk("R3 data", fifo_data, 8'h41); idle(2);
    send(OFF1);
    chk("R3 xoff consumed", fifo_wr, 0); chk("R6 irq", irq, 1);
    chk("R9 no halt before boundary", tx_halt, 0);
    idle(1); chk("R6 irq one cycle", irq, 0);
    bound = 1; idle(1); chk("R9 halt at boundary", tx_halt, 1); bound = 0;
    idle(1);
    send(ON1); chk("R3 xon consumed", fifo_wr, 0); chk("R9 resume", tx_halt, 0);
    idle(2);

    // R4/R5: double mode
    dbl = 1; idle(1);
    send(OFF1); chk("R4 first held", fifo_wr, 0); chk("R4 no irq yet", irq, 0); idle(2);
    send(OFF2); chk("R4 pair consumed", fifo_wr, 0); chk("R6 irq dbl", irq, 1);
    bound = 1; idle(1); chk("R4 halted", tx_halt, 1); bound = 0; idle(1);
    send(ON1); chk("R4 on1 held", fifo_wr, 0); idle(2);
    send(8'h55);
    chk("R5 held written", fifo_wr, 1); chk("R5 held data", fifo_data, ON1);
    idle(1);
    chk("R5 second written", fifo_wr, 1); chk("R5 second data", fifo_data, 8'h55);
    chk("R4 still halted", tx_halt, 1);
    idle(1);
    send(ON1); idle(2);
    send(ON2); chk("R4 resume pair consumed", fifo_wr, 0); chk("R4 resumed", tx_halt, 0);
    idle(2);

    // R7: any-character resume, single mode
    dbl = 0; any = 1; bound = 1; idle(1);
    send(OFF1); chk("R7 halted", tx_halt, 1); idle(2);
    send(8'h33);
    chk("R7 any wr", fifo_wr, 1); chk("R7 any data", fifo_data, 8'h33);
    chk("R7 resumed", tx_halt, 0);
    idle(2);

    // R8: double mode corner, second resume code leaks
    dbl = 1; idle(1);
    send(OFF1); idle(2);
    send(OFF2); chk("R8 halted", tx_halt, 1); idle(2);
    send(ON1); chk("R8 on1 consumed", fifo_wr, 0); chk("R8 resumed", tx_halt, 0); idle(2);
    send(ON2); chk("R8 on2 leaks wr", fifo_wr, 1); chk("R8 on2 data", fifo_data, ON2);
    idle(2);

    // R10: disable clears halt and partial match
    any = 0; idle(1);
    send(OFF1); idle(2);
    send(OFF2); chk("R10 halted", tx_halt, 1); idle(2);
    send(OFF1); chk("R10 partial held", fifo_wr, 0);
    fc_en = 0; idle(1); chk("R10 halt cleared", tx_halt, 0);
    fc_en = 1; idle(1);
    send(OFF2); chk("R10 lone second wr", fifo_wr, 1); chk("R10 lone second data", fifo_data, OFF2);
    idle(1); chk("R10 held dropped", fifo_wr, 0);
    bound = 0; idle(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule